// File: doc/BRIEF.md
# Loopback Strobe-Margin Sweep Controller

This block is a self-test sequencer for a parallel, strobe-clocked bus whose drivers are looped back into their own receivers. Each lane drives a stressing pattern: every lane toggles on every beat, and one victim lane per burst moves against the rest. The looped-back data is captured with a strobe whose delay the controller sets through a delay code. The same loop therefore measures both the drive timing and the receive timing.

For each of two strobe directions the controller steps the delay code upward from zero. One direction approaches the early edge (output valid plus setup) and the other approaches the late edge (valid-after plus hold). Each step runs a programmable number of full-speed bursts. The first code at which a lane miscompares becomes that lane's margin for that direction. Once every lane has failed, or the top code has been tried, the sweep for that direction ends.

After both sweeps, the controller computes the minimum, maximum and median margin of the group for each direction. It flags every lane whose margin lies further from the median than a programmable threshold, since such a lane points to a locally defective buffer. A one-cycle done pulse marks the end of the run, and the results hold until the next start.

Top module: `swp_margin_bist`

## Requirements
- R1: After reset, done_o, tx_en_o, dly_code_o, dly_dir_o, miscmp_o, all margins, no-fail bits, fault bits and statistics are zero.
- R2: While tx_en_o is high, the data follows a fixed pattern. Beat j of burst b within a step drives all lanes to j[0], with lane (b mod LANES) inverted. Each step holds BURST_LEN beats per burst.
- R3: The early-edge sweep (dly_dir_o = 0) runs first and the late-edge sweep (dly_dir_o = 1) runs second. Each sweep starts at code 0 and adds one per step. Each step drives max(bursts_i, 1) bursts, so tx_en_o stays high for that many times BURST_LEN cycles per step.
- R4: A lane's margin in a direction is the lowest code at which any of its captures miscompared. Miscompares at higher codes do not change it.
- R5: A lane with no miscompare up to code 2^CODE_W-1 reports margin 2^CODE_W-1 with its no-fail bit set. A lane that first fails at that code reports the same margin with the no-fail bit clear.
- R6: A direction's sweep ends after the first step by which every lane has failed at least once, or after the step at the top code.
- R7: miscmp_o[i] pulses once for every compared beat in which rx_cap_i[i] differs from the value that lane transmitted LOOP_LAT cycles earlier. It stays low otherwise.
- R8: For each direction, min_o, max_o and med_o report the minimum, the maximum and the element of rank (LANES-1)/2, counted from zero in ascending order, of the lane margins. The early-edge direction occupies bits [CODE_W-1:0] and the late-edge direction occupies the bits above.
- R9: fault_o[i] is set when the absolute difference between lane i's margin and that direction's median exceeds thresh_i, in either direction.
- R10: done_o is high for exactly one cycle at the end of a run, and every result output holds its value until the next accepted start.
- R11: bursts_i and thresh_i are captured when a start is accepted, and a start pulse during a run has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse, accepted when idle |
| bursts_i | input | NB_W | Bursts per delay step (0 acts as 1) |
| thresh_i | input | CODE_W | Allowed deviation from the median |
| rx_cap_i | input | LANES | Looped-back data captured by the delayed strobe |
| tx_data_o | output | LANES | Pattern driven on the lanes |
| tx_en_o | output | 1 | Lane drive enable; high on pattern beats |
| dly_code_o | output | CODE_W | Strobe delay code |
| dly_dir_o | output | 1 | 0: early-edge sweep, 1: late-edge sweep |
| miscmp_o | output | LANES | Per-lane compare-error pulse |
| marg_setup_o | output | LANES*CODE_W | Early-edge margin per lane, lane 0 lowest |
| marg_hold_o | output | LANES*CODE_W | Late-edge margin per lane |
| nofail_setup_o | output | LANES | No early-edge failure found |
| nofail_hold_o | output | LANES | No late-edge failure found |
| fault_o | output | LANES | Lane outside the group distribution |
| min_o | output | 2*CODE_W | Minimum margin per direction |
| max_o | output | 2*CODE_W | Maximum margin per direction |
| med_o | output | 2*CODE_W | Median margin per direction |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume that the loopback returns each transmitted beat exactly LOOP_LAT cycles later. They also assume that the delay code and direction stay fixed for the whole of a step, so that any miscompare belongs to the code shown on dly_code_o.

The bench model follows both rules. It is a LOOP_LAT-deep register chain from tx_data_o to rx_cap_i. It corrupts a lane only through a mask computed from the current code and direction and from per-lane failure windows. Inputs change only at falling edges, and start is pulsed only for a single cycle.

// File: rtl/swp_pkg.sv
package swp_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_RUN,
    S_DRAIN,
    S_STEP,
    S_STATS,
    S_FLAG
  } swp_state_e;
endpackage

// File: rtl/swp_patgen.sv
module swp_patgen #(
  parameter int LANES = 8,
  localparam int LW = $clog2(LANES)
) (
  input  logic             beat_odd,
  input  logic [LW-1:0]    victim,
  output logic [LANES-1:0] pat
);
  always_comb begin
    pat = {LANES{beat_odd}} ^ (LANES'(1) << victim);
  end
endmodule

// File: rtl/swp_lane.sv
module swp_lane #(
  parameter int CODE_W   = 8,
  parameter int LOOP_LAT = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              tx_bit,
  input  logic              tx_vld,
  input  logic              rx_bit,
  input  logic              step_end,
  input  logic              dir,
  input  logic              finish,
  input  logic [CODE_W-1:0] code,
  output logic              miscmp_o,
  output logic              hit_o,
  output logic [CODE_W-1:0] marg_s_o,
  output logic [CODE_W-1:0] marg_h_o,
  output logic              nf_s_o,
  output logic              nf_h_o
);
  logic [LOOP_LAT-1:0] exp_q;
  logic [LOOP_LAT-1:0] vld_q;
  logic                err_q;
  logic                found_q;
  logic                mism;

  assign mism  = vld_q[LOOP_LAT-1] & (rx_bit ^ exp_q[LOOP_LAT-1]);
  assign hit_o = found_q | err_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      exp_q    <= '0;
      vld_q    <= '0;
      err_q    <= 1'b0;
      found_q  <= 1'b0;
      miscmp_o <= 1'b0;
      marg_s_o <= '0;
      marg_h_o <= '0;
      nf_s_o   <= 1'b0;
      nf_h_o   <= 1'b0;
    end else begin
      exp_q[0] <= tx_bit;
      vld_q[0] <= tx_vld;
      for (int k = 1; k < LOOP_LAT; k++) begin
        exp_q[k] <= exp_q[k-1];
        vld_q[k] <= vld_q[k-1];
      end
      miscmp_o <= mism;
      if (step_end) begin
        err_q <= 1'b0;
        if (err_q && !found_q) begin
          if (dir) marg_h_o <= code;
          else     marg_s_o <= code;
        end
        if (finish && !found_q && !err_q) begin
          if (dir) begin
            marg_h_o <= '1;
            nf_h_o   <= 1'b1;
          end else begin
            marg_s_o <= '1;
            nf_s_o   <= 1'b1;
          end
        end
        found_q <= finish ? 1'b0 : (found_q | err_q);
      end else if (mism) begin
        err_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/swp_stats.sv
module swp_stats #(
  parameter int LANES  = 8,
  parameter int CODE_W = 8,
  localparam int LW    = $clog2(LANES),
  localparam int CNT_W = $clog2(LANES + 1),
  localparam int MED_K = (LANES - 1) / 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    clr,
  input  logic                    step,
  input  logic                    sdir,
  input  logic [LW-1:0]           slane,
  input  logic                    flag_en,
  input  logic [CODE_W-1:0]       thr,
  input  logic [LANES*CODE_W-1:0] marg_s,
  input  logic [LANES*CODE_W-1:0] marg_h,
  output logic [2*CODE_W-1:0]     min_o,
  output logic [2*CODE_W-1:0]     max_o,
  output logic [2*CODE_W-1:0]     med_o,
  output logic [LANES-1:0]        fault_o
);
  logic [CODE_W-1:0] vs [LANES];
  logic [CODE_W-1:0] cand;
  logic [CNT_W-1:0]  lt_cnt, le_cnt;
  logic              is_med;
  logic [CODE_W-1:0] mn_q [2];
  logic [CODE_W-1:0] mx_q [2];
  logic [CODE_W-1:0] md_q [2];

  function automatic logic [CODE_W-1:0] absd(input logic [CODE_W-1:0] a,
                                             input logic [CODE_W-1:0] b);
    return (a > b) ? (a - b) : (b - a);
  endfunction

  always_comb begin
    for (int j = 0; j < LANES; j++) begin
      vs[j] = sdir ? marg_h[j*CODE_W +: CODE_W] : marg_s[j*CODE_W +: CODE_W];
    end
    cand   = vs[slane];
    lt_cnt = '0;
    le_cnt = '0;
    for (int j = 0; j < LANES; j++) begin
      lt_cnt = lt_cnt + CNT_W'(vs[j] <  cand);
      le_cnt = le_cnt + CNT_W'(vs[j] <= cand);
    end
    is_med = (lt_cnt <= CNT_W'(MED_K)) && (le_cnt > CNT_W'(MED_K));
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      for (int d = 0; d < 2; d++) begin
        mn_q[d] <= '0;
        mx_q[d] <= '0;
        md_q[d] <= '0;
      end
      fault_o <= '0;
    end else begin
      if (step) begin
        if (slane == '0) begin
          mn_q[sdir] <= cand;
          mx_q[sdir] <= cand;
        end else begin
          if (cand < mn_q[sdir]) mn_q[sdir] <= cand;
          if (cand > mx_q[sdir]) mx_q[sdir] <= cand;
        end
        if (is_med) md_q[sdir] <= cand;
      end
      if (flag_en) begin
        for (int i = 0; i < LANES; i++) begin
          fault_o[i] <= (absd(marg_s[i*CODE_W +: CODE_W], md_q[0]) > thr) ||
                        (absd(marg_h[i*CODE_W +: CODE_W], md_q[1]) > thr);
        end
      end
    end
  end

  assign min_o = {mn_q[1], mn_q[0]};
  assign max_o = {mx_q[1], mx_q[0]};
  assign med_o = {md_q[1], md_q[0]};
endmodule

// File: rtl/swp_margin_bist.sv
module swp_margin_bist
  import swp_pkg::*;
#(
  parameter int LANES     = 8,
  parameter int CODE_W    = 8,
  parameter int NB_W      = 4,
  parameter int BURST_LEN = 8,
  parameter int LOOP_LAT  = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start_i,
  input  logic [NB_W-1:0]         bursts_i,
  input  logic [CODE_W-1:0]       thresh_i,
  input  logic [LANES-1:0]        rx_cap_i,
  output logic [LANES-1:0]        tx_data_o,
  output logic                    tx_en_o,
  output logic [CODE_W-1:0]       dly_code_o,
  output logic                    dly_dir_o,
  output logic [LANES-1:0]        miscmp_o,
  output logic [LANES*CODE_W-1:0] marg_setup_o,
  output logic [LANES*CODE_W-1:0] marg_hold_o,
  output logic [LANES-1:0]        nofail_setup_o,
  output logic [LANES-1:0]        nofail_hold_o,
  output logic [LANES-1:0]        fault_o,
  output logic [2*CODE_W-1:0]     min_o,
  output logic [2*CODE_W-1:0]     max_o,
  output logic [2*CODE_W-1:0]     med_o,
  output logic                    done_o
);
  localparam int LW   = $clog2(LANES);
  localparam int BL_W = $clog2(BURST_LEN);
  localparam int DR_W = $clog2(LOOP_LAT + 1);
  localparam logic [CODE_W-1:0] CODE_MAX = '1;

  swp_state_e        state_q;
  logic [CODE_W-1:0] code_q;
  logic              dir_q;
  logic [BL_W-1:0]   beat_q;
  logic [NB_W-1:0]   burst_q;
  logic [LW-1:0]     vic_q;
  logic [DR_W-1:0]   drain_q;
  logic [NB_W-1:0]   nb_q;
  logic [CODE_W-1:0] thr_q;
  logic              s_dir_q;
  logic [LW-1:0]     s_lane_q;
  logic [LANES-1:0]  tx_data_q;
  logic              tx_en_q;
  logic              done_q;

  logic              clr, step_end, finish, stats_step, flag_en;
  logic              last_beat, last_burst, last_vic, last_slane;
  logic [LANES-1:0]  pat;
  logic [LANES-1:0]  lane_hit;

  assign clr        = (state_q == S_IDLE) && start_i;
  assign step_end   = (state_q == S_STEP);
  assign stats_step = (state_q == S_STATS);
  assign flag_en    = (state_q == S_FLAG);
  assign finish     = (&lane_hit) || (code_q == CODE_MAX);
  assign last_beat  = (beat_q == BL_W'(BURST_LEN - 1));
  assign last_burst = (({1'b0, burst_q} + 1'b1) >= {1'b0, nb_q});
  assign last_vic   = (vic_q == LW'(LANES - 1));
  assign last_slane = (s_lane_q == LW'(LANES - 1));

  swp_patgen #(.LANES(LANES)) u_pat (
    .beat_odd (beat_q[0]),
    .victim   (vic_q),
    .pat      (pat)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= S_IDLE;
      code_q    <= '0;
      dir_q     <= 1'b0;
      beat_q    <= '0;
      burst_q   <= '0;
      vic_q     <= '0;
      drain_q   <= '0;
      nb_q      <= '0;
      thr_q     <= '0;
      s_dir_q   <= 1'b0;
      s_lane_q  <= '0;
      tx_data_q <= '0;
      tx_en_q   <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      tx_en_q   <= (state_q == S_RUN);
      tx_data_q <= (state_q == S_RUN) ? pat : '0;
      done_q    <= 1'b0;
      case (state_q)
        S_IDLE: begin
          if (start_i) begin
            nb_q    <= bursts_i;
            thr_q   <= thresh_i;
            code_q  <= '0;
            dir_q   <= 1'b0;
            beat_q  <= '0;
            burst_q <= '0;
            vic_q   <= '0;
            state_q <= S_RUN;
          end
        end
        S_RUN: begin
          beat_q <= beat_q + 1'b1;
          if (last_beat) begin
            beat_q  <= '0;
            vic_q   <= last_vic ? '0 : vic_q + 1'b1;
            burst_q <= burst_q + 1'b1;
            if (last_burst) begin
              drain_q <= '0;
              state_q <= S_DRAIN;
            end
          end
        end
        S_DRAIN: begin
          drain_q <= drain_q + 1'b1;
          if (drain_q == DR_W'(LOOP_LAT)) state_q <= S_STEP;
        end
        S_STEP: begin
          beat_q  <= '0;
          burst_q <= '0;
          vic_q   <= '0;
          if (finish) begin
            code_q <= '0;
            if (!dir_q) begin
              dir_q   <= 1'b1;
              state_q <= S_RUN;
            end else begin
              s_dir_q  <= 1'b0;
              s_lane_q <= '0;
              state_q  <= S_STATS;
            end
          end else begin
            code_q  <= code_q + 1'b1;
            state_q <= S_RUN;
          end
        end
        S_STATS: begin
          s_lane_q <= s_lane_q + 1'b1;
          if (last_slane) begin
            s_lane_q <= '0;
            if (!s_dir_q) s_dir_q <= 1'b1;
            else          state_q <= S_FLAG;
          end
        end
        S_FLAG: begin
          done_q  <= 1'b1;
          dir_q   <= 1'b0;
          state_q <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    swp_lane #(.CODE_W(CODE_W), .LOOP_LAT(LOOP_LAT)) u_lane (
      .clk      (clk),
      .rst      (rst),
      .clr      (clr),
      .tx_bit   (tx_data_q[g]),
      .tx_vld   (tx_en_q),
      .rx_bit   (rx_cap_i[g]),
      .step_end (step_end),
      .dir      (dir_q),
      .finish   (finish),
      .code     (code_q),
      .miscmp_o (miscmp_o[g]),
      .hit_o    (lane_hit[g]),
      .marg_s_o (marg_setup_o[g*CODE_W +: CODE_W]),
      .marg_h_o (marg_hold_o[g*CODE_W +: CODE_W]),
      .nf_s_o   (nofail_setup_o[g]),
      .nf_h_o   (nofail_hold_o[g])
    );
  end

  swp_stats #(.LANES(LANES), .CODE_W(CODE_W)) u_stats (
    .clk     (clk),
    .rst     (rst),
    .clr     (clr),
    .step    (stats_step),
    .sdir    (s_dir_q),
    .slane   (s_lane_q),
    .flag_en (flag_en),
    .thr     (thr_q),
    .marg_s  (marg_setup_o),
    .marg_h  (marg_hold_o),
    .min_o   (min_o),
    .max_o   (max_o),
    .med_o   (med_o),
    .fault_o (fault_o)
  );

  assign tx_data_o  = tx_data_q;
  assign tx_en_o    = tx_en_q;
  assign dly_code_o = code_q;
  assign dly_dir_o  = dir_q;
  assign done_o     = done_q;
endmodule

// File: rtl/swp_margin_bist_chk.sv
module swp_margin_bist_chk #(
  parameter int LANES  = 8,
  parameter int CODE_W = 8
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    start_i,
  input logic                    done_o,
  input logic                    tx_en_o,
  input logic [LANES-1:0]        tx_data_o,
  input logic [CODE_W-1:0]       dly_code_o,
  input logic [LANES*CODE_W-1:0] marg_setup_o,
  input logic [LANES*CODE_W-1:0] marg_hold_o,
  input logic [LANES-1:0]        nofail_setup_o,
  input logic [LANES-1:0]        nofail_hold_o,
  input logic [LANES-1:0]        fault_o
);
  logic fin_q;

  always_ff @(posedge clk) begin
    if (rst)          fin_q <= 1'b0;
    else if (start_i) fin_q <= 1'b0;
    else if (done_o)  fin_q <= 1'b1;
  end

  // R10: completion pulse lasts a single cycle
  a_r10_done_single: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R10: results frozen after completion until a new start
  a_r10_results_hold: assert property (@(posedge clk) disable iff (rst)
    (fin_q && !start_i) |=> ($stable(marg_setup_o) && $stable(marg_hold_o) &&
                             $stable(fault_o) && $stable(nofail_setup_o) &&
                             $stable(nofail_hold_o)));

  // R3: delay code only advances by one or restarts at zero
  a_r3_code_step: assert property (@(posedge clk) disable iff (rst)
    !$stable(dly_code_o) |->
      ((dly_code_o == CODE_W'($past(dly_code_o) + 1'b1)) || (dly_code_o == '0)));

  // R2: driven pattern has exactly one lane against the rest
  a_r2_one_victim: assert property (@(posedge clk) disable iff (rst)
    tx_en_o |-> (($countones(tx_data_o) == 1) || ($countones(tx_data_o) == LANES - 1)));

  // R5: a no-fail lane reports the top code
  always_comb begin
    if (!rst) begin
      for (int i = 0; i < LANES; i++) begin
        if (nofail_setup_o[i])
          a_r5_nofail_top_s: assert (marg_setup_o[i*CODE_W +: CODE_W] == {CODE_W{1'b1}});
        if (nofail_hold_o[i])
          a_r5_nofail_top_h: assert (marg_hold_o[i*CODE_W +: CODE_W] == {CODE_W{1'b1}});
      end
    end
  end
endmodule

bind swp_margin_bist swp_margin_bist_chk #(.LANES(LANES), .CODE_W(CODE_W)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .start_i        (start_i),
  .done_o         (done_o),
  .tx_en_o        (tx_en_o),
  .tx_data_o      (tx_data_o),
  .dly_code_o     (dly_code_o),
  .marg_setup_o   (marg_setup_o),
  .marg_hold_o    (marg_hold_o),
  .nofail_setup_o (nofail_setup_o),
  .nofail_hold_o  (nofail_hold_o),
  .fault_o        (fault_o)
);

// File: tb/swp_margin_bist_tb.sv
module swp_margin_bist_tb;
  localparam int LANES = 8;
  localparam int CODE_W = 8;
  localparam int NB_W = 4;
  localparam int BL = 8;
  localparam int LAT = 2;
  localparam int NV = 5;

  // failure thresholds per lane, lane 0 in the low 9 bits; 256 = never fails
  localparam logic [71:0] TS [NV] = '{
    {9'd12, 9'd11, 9'd10, 9'd11, 9'd12, 9'd10, 9'd11, 9'd10},
    {9'd20, 9'd21, 9'd22, 9'd20, 9'd2,  9'd19, 9'd21, 9'd20},
    {9'd30, 9'd256, 9'd30, 9'd30, 9'd30, 9'd30, 9'd30, 9'd30},
    {9'd7,  9'd7,  9'd7,  9'd7,  9'd7,  9'd7,  9'd7,  9'd8},
    {9'd0,  9'd0,  9'd0,  9'd0,  9'd0,  9'd0,  9'd0,  9'd0}
  };
  localparam logic [71:0] TH [NV] = '{
    {9'd8,  9'd8,  9'd9,  9'd9,  9'd8,  9'd8,  9'd9,  9'd8},
    {9'd15, 9'd16, 9'd40, 9'd15, 9'd14, 9'd15, 9'd16, 9'd15},
    {9'd5,  9'd256, 9'd5, 9'd5,  9'd5,  9'd5,  9'd255, 9'd5},
    {9'd3,  9'd3,  9'd3,  9'd3,  9'd3,  9'd3,  9'd3,  9'd3},
    {9'd0,  9'd0,  9'd0,  9'd0,  9'd0,  9'd0,  9'd0,  9'd0}
  };
  localparam logic [8:0] WV  [NV] = '{9'd255, 9'd2, 9'd255, 9'd255, 9'd1};
  localparam logic [3:0] NBV [NV] = '{4'd1, 4'd2, 4'd1, 4'd3, 4'd0};
  localparam logic [7:0] THV [NV] = '{8'd3, 8'd4, 8'd10, 8'd0, 8'd0};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0;
  logic [NB_W-1:0] bursts_i = '0;
  logic [CODE_W-1:0] thresh_i = '0;
  logic [LANES-1:0] rx_cap_i;
  logic [LANES-1:0] tx_data_o, miscmp_o, nofail_setup_o, nofail_hold_o, fault_o;
  logic tx_en_o, dly_dir_o, done_o;
  logic [CODE_W-1:0] dly_code_o;
  logic [LANES*CODE_W-1:0] marg_setup_o, marg_hold_o;
  logic [2*CODE_W-1:0] min_o, max_o, med_o;

  always #10 clk = ~clk;

  swp_margin_bist #(.LANES(LANES), .CODE_W(CODE_W), .NB_W(NB_W),
                    .BURST_LEN(BL), .LOOP_LAT(LAT)) u_dut (
    .clk(clk), .rst(rst), .start_i(start_i), .bursts_i(bursts_i),
    .thresh_i(thresh_i), .rx_cap_i(rx_cap_i), .tx_data_o(tx_data_o),
    .tx_en_o(tx_en_o), .dly_code_o(dly_code_o), .dly_dir_o(dly_dir_o),
    .miscmp_o(miscmp_o), .marg_setup_o(marg_setup_o), .marg_hold_o(marg_hold_o),
    .nofail_setup_o(nofail_setup_o), .nofail_hold_o(nofail_hold_o),
    .fault_o(fault_o), .min_o(min_o), .max_o(max_o), .med_o(med_o),
    .done_o(done_o)
  );

  // loopback model
  logic [8:0] ts [LANES];
  logic [8:0] th [LANES];
  logic [9:0] win;
  logic [LANES-1:0] dl [LAT];
  logic [LANES-1:0] fmask;

  always @(posedge clk) begin
    dl[0] <= tx_data_o;
    for (int k = 1; k < LAT; k++) dl[k] <= dl[k-1];
  end

  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      logic [9:0] t;
      t = {1'b0, (dly_dir_o ? th[i] : ts[i])};
      fmask[i] = ({2'b0, dly_code_o} >= t) && ({2'b0, dly_code_o} < t + win);
    end
  end
  assign rx_cap_i = dl[LAT-1] ^ fmask;

  int nchk = 0;
  int nerr = 0;
  int txcnt = 0;
  int donecnt = 0;
  int patbad = 0;
  int kbeat = 0;
  int codemax [2];
  int miscnt [LANES];

  always @(negedge clk) begin
    if (tx_en_o) begin
      int j, b;
      logic [LANES-1:0] ep;
      j = kbeat % BL;
      b = (kbeat / BL) % LANES;
      ep = {LANES{j[0]}} ^ (LANES'(1) << b);
      if (tx_data_o !== ep) patbad++;
      kbeat++;
      txcnt++;
      if (int'(dly_code_o) > codemax[dly_dir_o]) codemax[dly_dir_o] = int'(dly_code_o);
    end else begin
      kbeat = 0;
    end
    for (int i = 0; i < LANES; i++) miscnt[i] += int'(miscmp_o[i]);
    if (done_o) donecnt++;
  end

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic int cnt_fail(input int t, input int stop, input int w);
    int hi;
    if (t > stop) return 0;
    hi = t + w - 1;
    if (hi > stop) hi = stop;
    return hi - t + 1;
  endfunction

  function automatic int median8(input int a [LANES]);
    int s [LANES];
    int tmp;
    s = a;
    for (int i = 0; i < LANES; i++)
      for (int j = 0; j < LANES - 1 - i; j++)
        if (s[j] > s[j+1]) begin tmp = s[j]; s[j] = s[j+1]; s[j+1] = tmp; end
    return s[(LANES-1)/2];
  endfunction

  task automatic run_vec(input int v, input bit poke);
    int ms [LANES];
    int mh [LANES];
    int stop_s, stop_h, nbe, md_s, md_h, cyc, ds, dh;
    logic [63:0] ems, emh;
    logic [7:0] enfs, enfh, eflt;
    logic [15:0] emin, emax, emed;
    int mn_s, mx_s, mn_h, mx_h;
    bit okmis;
    // set up the loopback model
    for (int i = 0; i < LANES; i++) begin
      ts[i] = TS[v][i*9 +: 9];
      th[i] = TH[v][i*9 +: 9];
    end
    win = {1'b0, WV[v]};
    txcnt = 0; donecnt = 0; patbad = 0;
    codemax[0] = 0; codemax[1] = 0;
    for (int i = 0; i < LANES; i++) miscnt[i] = 0;
    // expectations from the requirements
    nbe = (NBV[v] == 0) ? 1 : int'(NBV[v]);
    stop_s = 0; stop_h = 0;
    for (int i = 0; i < LANES; i++) begin
      ms[i] = (ts[i] > 255) ? 255 : int'(ts[i]);
      mh[i] = (th[i] > 255) ? 255 : int'(th[i]);
      enfs[i] = ts[i] > 255;
      enfh[i] = th[i] > 255;
      if (ms[i] > stop_s) stop_s = ms[i];
      if (mh[i] > stop_h) stop_h = mh[i];
      ems[i*8 +: 8] = 8'(ms[i]);
      emh[i*8 +: 8] = 8'(mh[i]);
    end
    md_s = median8(ms);
    md_h = median8(mh);
    mn_s = 255; mx_s = 0; mn_h = 255; mx_h = 0;
    for (int i = 0; i < LANES; i++) begin
      if (ms[i] < mn_s) mn_s = ms[i];
      if (ms[i] > mx_s) mx_s = ms[i];
      if (mh[i] < mn_h) mn_h = mh[i];
      if (mh[i] > mx_h) mx_h = mh[i];
      ds = (ms[i] > md_s) ? ms[i] - md_s : md_s - ms[i];
      dh = (mh[i] > md_h) ? mh[i] - md_h : md_h - mh[i];
      eflt[i] = (ds > int'(THV[v])) || (dh > int'(THV[v]));
    end
    emin = {8'(mn_h), 8'(mn_s)};
    emax = {8'(mx_h), 8'(mx_s)};
    emed = {8'(md_h), 8'(md_s)};
    // launch
    bursts_i = NBV[v];
    thresh_i = THV[v];
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    if (poke) begin
      repeat (50) @(negedge clk);
      bursts_i = 4'd7;
      thresh_i = 8'd200;
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
    end
    cyc = 0;
    while (!done_o && cyc < 60000) begin
      @(negedge clk);
      cyc++;
    end
    chk($sformatf("R10 v%0d run completes", v), 128'(done_o), 128'(1));
    repeat (3) @(negedge clk);
    chk($sformatf("R4 v%0d early-edge margins", v), 128'(marg_setup_o), 128'(ems));
    chk($sformatf("R4 v%0d late-edge margins", v), 128'(marg_hold_o), 128'(emh));
    chk($sformatf("R5 v%0d no-fail bits", v), {112'd0, nofail_hold_o, nofail_setup_o},
        {112'd0, enfh, enfs});
    chk($sformatf("R8 v%0d min", v), 128'(min_o), 128'(emin));
    chk($sformatf("R8 v%0d max", v), 128'(max_o), 128'(emax));
    chk($sformatf("R8 v%0d median", v), 128'(med_o), 128'(emed));
    chk($sformatf("R9 v%0d fault lanes", v), 128'(fault_o), 128'(eflt));
    chk($sformatf("R3 v%0d beats driven", v), 128'(txcnt),
        128'((stop_s + 1 + stop_h + 1) * nbe * BL));
    chk($sformatf("R6 v%0d last code per sweep", v), 128'({codemax[1], codemax[0]}),
        128'({stop_h, stop_s}));
    chk($sformatf("R2 v%0d pattern mismatches", v), 128'(patbad), 128'(0));
    chk($sformatf("R10 v%0d done pulse count", v), 128'(donecnt), 128'(1));
    okmis = 1'b1;
    for (int i = 0; i < LANES; i++) begin
      int e;
      e = (cnt_fail(int'(ts[i]), stop_s, int'(win)) +
           cnt_fail(int'(th[i]), stop_h, int'(win))) * nbe * BL;
      if (miscnt[i] != e) begin
        okmis = 1'b0;
        $display("FAIL R7 v%0d lane %0d miscompares act=%0d exp=%0d", v, i, miscnt[i], e);
      end
    end
    nchk++;
    if (!okmis) nerr++;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog act=timeout exp=finished");
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    logic [63:0] sv_s, sv_h;
    logic [7:0] sv_f;
    for (int i = 0; i < LANES; i++) begin ts[i] = 9'd256; th[i] = 9'd256; end
    win = 10'd1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: idle state after reset
    chk("R1 control outputs", {120'd0, done_o, tx_en_o, dly_dir_o, miscmp_o != 0, 4'd0},
        128'd0);
    chk("R1 delay code", 128'(dly_code_o), 128'd0);
    chk("R1 margins", {marg_hold_o, marg_setup_o}, 128'd0);
    chk("R1 flags", {104'd0, fault_o, nofail_hold_o, nofail_setup_o}, 128'd0);
    chk("R1 statistics", {80'd0, min_o, max_o, med_o}, 128'd0);

    for (int v = 0; v < NV; v++) begin
      run_vec(v, v == 1);   // vector 1 also exercises R11
      if (v == 3) begin
        // R10: results hold with inputs changing while idle
        sv_s = marg_setup_o; sv_h = marg_hold_o; sv_f = fault_o;
        thresh_i = 8'hff; bursts_i = 4'd9;
        repeat (30) @(negedge clk);
        chk("R10 results hold after done", {sv_f, sv_h, sv_s},
            {fault_o, marg_hold_o, marg_setup_o});
        chk("R10 idle no drive", 128'(tx_en_o), 128'd0);
      end
    end

    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule